// File: doc/BRIEF.md
# Reservation-Guarded Shared Word Memory

This block is a small word-addressed memory shared by two requesting agents. It adds a reservation monitor so that each agent can build an atomic read-modify-write sequence from two operations. A reserving load returns a word and records a reservation on that address for the agent. A conditional store writes only if that reservation is still intact. The conditional store returns an explicit one-bit status with its response. Software must branch on this status: a retry loop that compares values in memory cannot see an update that left the same value, or one that happened after its own attempt.

Each agent presents a request with an operation code, a word address and write data, and holds it until `req_ready` grants it. Exactly one access is performed per cycle. Agent 0 has fixed priority. The response (the word read before any write, plus the status bit) appears one cycle after the grant. A per-agent clear input models a context switch or interrupt and drops that agent's reservation. The asynchronous active-low reset is released through a two-stage synchroniser. After `rst_n` rises, the block ignores requests for two clock edges.

Top module: `llsc_monitor`

## Requirements
- R1: A reserving load (op code 2'b10) returns the addressed word and records a reservation for the issuing agent on that full word address.
- R2: A conditional store (op code 2'b11) writes memory only when the issuer holds a valid reservation on the same address. Its status is 1 when written and 0 when suppressed. `resp_rdata` carries the word as it was before the access.
- R3: Every conditional store clears the issuing agent's reservation, whether or not it succeeds.
- R4: A write by the other agent (plain store, op code 2'b01, or successful conditional store) to a reserved address breaks that reservation. The later conditional store fails and writes nothing.
- R5: A write by the other agent to a different address leaves the reservation intact.
- R6: An agent's own plain store to its reserved address does not clear its reservation.
- R7: A new reserving load by the same agent replaces its previous reservation address.
- R8: A high `rsv_clr` bit for an agent drops that agent's reservation. It wins over a reserving load granted to that agent in the same cycle.
- R9: When both agents request, agent 0 is granted first and agent 1 is held with `req_ready` low until the next cycle. Agent 1's access then sees the state left by agent 0's access.
- R10: A conditional store with no earlier reservation (including the first one after reset) fails with status 0 and leaves memory unchanged.
- R11: `resp_valid` pulses for one cycle, one cycle after the grant. The status is 0 for every operation other than the conditional store (plain load is 2'b00). After reset, no response is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 2 | Request present, one bit per agent |
| req_op | input | 2x2 | Operation per agent: 00 load, 01 store, 10 reserving load, 11 conditional store |
| req_addr | input | 2xADDR_W | Word address per agent |
| req_wdata | input | 2xDATA_W | Write data per agent |
| rsv_clr | input | 2 | Drop that agent's reservation |
| req_ready | output | 2 | Request granted this cycle |
| resp_valid | output | 2 | Response valid, one cycle after the grant |
| resp_rdata | output | 2xDATA_W | Word at the address before the access |
| resp_status | output | 2 | Conditional-store success flag |

## Verification
The conditional store is driven in several contexts: with no prior reservation, right after a matching reservation, a second time after a success, after a foreign write to the same and to a different address, after the agent's own plain store, after the reservation was moved, and after a clear. Each context separates one way of updating the reservation from the others. The foreign-write case is run both with a plain store and with a winning conditional store. Same-cycle requests from both agents check that the grant order is followed and that the held agent sees the value the first agent wrote.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  localparam int N_AGT = 2;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LL    = 2'b10,
    OP_SC    = 2'b11
  } op_e;
endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
  parameter int N     = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] sel,
  output logic             any
);
  always_comb begin
    gnt = '0;
    sel = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (valid[i] && !any) begin
        gnt[i] = 1'b1;
        sel    = IDX_W'(i);
        any    = 1'b1;
      end
    end
  end

  assert_gnt_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  assert_low_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid[0] && valid[1]) |-> (gnt[0] && !gnt[1]));
endmodule

// File: rtl/llsc_rsv.sv
module llsc_rsv
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own_acc,
  input  op_e               own_op,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              oth_wr,
  input  logic [ADDR_W-1:0] oth_addr,
  input  logic              clr,
  output logic              hit
);
  logic              v_q, v_d;
  logic [ADDR_W-1:0] a_q, a_d;

  always_comb begin
    v_d = v_q;
    a_d = a_q;
    if (own_acc) begin
      if (own_op == OP_LL) begin
        v_d = 1'b1;
        a_d = own_addr;
      end else if (own_op == OP_SC) begin
        v_d = 1'b0;
      end
    end else if (oth_wr && v_q && (oth_addr == a_q)) begin
      v_d = 1'b0;
    end
    if (clr) v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      a_q <= '0;
    end else begin
      v_q <= v_d;
      if (own_acc && own_op == OP_LL) a_q <= a_d;
    end
  end

  assign hit = v_q && (a_q == own_addr);

  assert_ll_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (own_acc && own_op == OP_LL && !clr) |=> (v_q && a_q == $past(own_addr)));
  assert_sc_consumes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (own_acc && own_op == OP_SC) |=> !v_q);
  assert_foreign_break_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_acc && oth_wr && v_q && oth_addr == a_q) |=> !v_q);
  assert_clr_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !v_q);
endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) words[addr] <= wdata;
  end

  assign rdata = words[addr];
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_AGT-1:0]              req_valid,
  input  logic [N_AGT-1:0][1:0]         req_op,
  input  logic [N_AGT-1:0][ADDR_W-1:0]  req_addr,
  input  logic [N_AGT-1:0][DATA_W-1:0]  req_wdata,
  input  logic [N_AGT-1:0]              rsv_clr,
  output logic [N_AGT-1:0]              req_ready,
  output logic [N_AGT-1:0]              resp_valid,
  output logic [N_AGT-1:0][DATA_W-1:0]  resp_rdata,
  output logic [N_AGT-1:0]              resp_status
);
  localparam int IDX_W = (N_AGT > 1) ? $clog2(N_AGT) : 1;

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [N_AGT-1:0] gnt;
  logic [IDX_W-1:0] sel;
  logic             any;
  logic [N_AGT-1:0] hit;
  logic [N_AGT-1:0] live_valid;

  assign live_valid = rst_q ? req_valid : '0;

  llsc_arbiter #(.N(N_AGT), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_q), .valid(live_valid), .gnt(gnt), .sel(sel), .any(any)
  );
  assign req_ready = gnt;

  op_e               acc_op;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic              wr_en;

  assign acc_op    = op_e'(req_op[sel]);
  assign acc_addr  = req_addr[sel];
  assign acc_wdata = req_wdata[sel];
  assign wr_en     = any && ((acc_op == OP_STORE) || (acc_op == OP_SC && hit[sel]));

  llsc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .addr(acc_addr), .wdata(acc_wdata), .rdata(mem_rdata)
  );

  for (genvar g = 0; g < N_AGT; g++) begin : g_agt
    logic              oth_wr;
    logic              vld_d;
    logic              st_d;
    logic [DATA_W-1:0] rd_d;

    assign oth_wr = wr_en && !gnt[g];

    llsc_rsv #(.ADDR_W(ADDR_W)) u_rsv (
      .clk(clk), .rst_n(rst_q),
      .own_acc(gnt[g]), .own_op(op_e'(req_op[g])), .own_addr(req_addr[g]),
      .oth_wr(oth_wr), .oth_addr(acc_addr),
      .clr(rsv_clr[g]), .hit(hit[g])
    );

    always_comb begin
      vld_d = gnt[g];
      st_d  = gnt[g] && (op_e'(req_op[g]) == OP_SC) && hit[g];
      rd_d  = resp_rdata[g];
      if (gnt[g]) rd_d = mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) begin
        resp_valid[g]  <= 1'b0;
        resp_status[g] <= 1'b0;
        resp_rdata[g]  <= '0;
      end else begin
        resp_valid[g]  <= vld_d;
        resp_status[g] <= st_d;
        if (gnt[g]) resp_rdata[g] <= rd_d;
      end
    end

    assert_resp_follows_R11: assert property (@(posedge clk) disable iff (!rst_q)
      gnt[g] |=> resp_valid[g]);
    assert_status_sc_only_R11: assert property (@(posedge clk) disable iff (!rst_q)
      (gnt[g] && op_e'(req_op[g]) != OP_SC) |=> !resp_status[g]);
    assert_status_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_q)
      !gnt[g] |=> !resp_status[g]);
  end
endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  import llsc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;

  logic                      clk;
  logic                      rst_n;
  logic [N_AGT-1:0]          req_valid;
  logic [N_AGT-1:0][1:0]     req_op;
  logic [N_AGT-1:0][AW-1:0]  req_addr;
  logic [N_AGT-1:0][DW-1:0]  req_wdata;
  logic [N_AGT-1:0]          rsv_clr;
  logic [N_AGT-1:0]          req_ready;
  logic [N_AGT-1:0]          resp_valid;
  logic [N_AGT-1:0][DW-1:0]  resp_rdata;
  logic [N_AGT-1:0]          resp_status;

  llsc_monitor #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  typedef struct {
    logic [DW-1:0] rd;
    bit            chk;
    bit            st;
    string         tag;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];
  int   n_chk;
  int   n_bad;
  bit   done;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int a, input logic [DW-1:0] rd, input bit chk, input bit st,
                      input string tag);
    exp_t e;
    e.rd = rd; e.chk = chk; e.st = st; e.tag = tag;
    if (a == 0) q0.push_back(e);
    else        q1.push_back(e);
  endtask

  task automatic issue(input int a, input op_e op, input logic [AW-1:0] ad,
                       input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                       input bit chk, input bit st, input string tag);
    @(negedge clk);
    req_valid[a] = 1'b1;
    req_op[a]    = op;
    req_addr[a]  = ad;
    req_wdata[a] = wd;
    #1;
    while (!req_ready[a]) begin
      @(negedge clk);
      #1;
    end
    push(a, rd, chk, st, tag);
    @(posedge clk);
    #1 req_valid[a] = 1'b0;
  endtask

  task automatic pair(input op_e op0, input logic [AW-1:0] ad0, input logic [DW-1:0] wd0,
                      input logic [DW-1:0] rd0, input bit chk0, input bit st0,
                      input op_e op1, input logic [AW-1:0] ad1, input logic [DW-1:0] wd1,
                      input logic [DW-1:0] rd1, input bit st1, input string tag);
    @(negedge clk);
    req_valid = 2'b11;
    req_op[0] = op0; req_addr[0] = ad0; req_wdata[0] = wd0;
    req_op[1] = op1; req_addr[1] = ad1; req_wdata[1] = wd1;
    #1;
    check(req_ready == 2'b01, {tag, " agent0 granted first"}, req_ready, 2'b01);
    push(0, rd0, chk0, st0, tag);
    @(posedge clk);
    #1 req_valid[0] = 1'b0;
    @(negedge clk);
    #1;
    check(req_ready == 2'b10, {tag, " agent1 granted next"}, req_ready, 2'b10);
    push(1, rd1, 1'b1, st1, tag);
    @(posedge clk);
    #1 req_valid[1] = 1'b0;
  endtask

  always @(negedge clk) begin
    for (int a = 0; a < N_AGT; a++) begin
      if (rst_n && resp_valid[a]) begin
        exp_t e;
        if ((a == 0 && q0.size() == 0) || (a == 1 && q1.size() == 0)) begin
          check(1'b0, "R11 unexpected response", a, 0);
        end else begin
          e = (a == 0) ? q0.pop_front() : q1.pop_front();
          check(resp_status[a] == e.st, {e.tag, " status"}, resp_status[a], e.st);
          if (e.chk)
            check(resp_rdata[a] == e.rd, {e.tag, " rdata"}, resp_rdata[a], e.rd);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0; rsv_clr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(resp_valid == 2'b00, "R11 reset no response", resp_valid, 0);
    check(req_ready == 2'b00, "R11 reset no grant", req_ready, 0);

    issue(0, OP_STORE, 4'd3, 16'h1111, 16'h0, 1'b0, 1'b0, "R11 init store");
    issue(0, OP_LOAD,  4'd3, 16'h0,    16'h1111, 1'b1, 1'b0, "R11 load status zero");
    // R10: conditional store with no reservation
    issue(1, OP_SC,    4'd3, 16'h2222, 16'h1111, 1'b1, 1'b0, "R10 sc without ll");
    issue(0, OP_LOAD,  4'd3, 16'h0,    16'h1111, 1'b1, 1'b0, "R10 memory unchanged");
    // R1 / R2
    issue(0, OP_LL,    4'd3, 16'h0,    16'h1111, 1'b1, 1'b0, "R1 ll returns word");
    issue(0, OP_SC,    4'd3, 16'h1112, 16'h1111, 1'b1, 1'b1, "R2 sc succeeds");
    issue(0, OP_LOAD,  4'd3, 16'h0,    16'h1112, 1'b1, 1'b0, "R2 sc wrote");
    // R3
    issue(0, OP_SC,    4'd3, 16'h9999, 16'h1112, 1'b1, 1'b0, "R3 second sc fails");
    issue(0, OP_LOAD,  4'd3, 16'h0,    16'h1112, 1'b1, 1'b0, "R3 no write");
    // R4 plain store by other agent
    issue(0, OP_LL,    4'd3, 16'h0,    16'h1112, 1'b1, 1'b0, "R4 ll");
    issue(1, OP_STORE, 4'd3, 16'h5555, 16'h1112, 1'b1, 1'b0, "R4 foreign store");
    issue(0, OP_SC,    4'd3, 16'h7777, 16'h5555, 1'b1, 1'b0, "R4 sc broken");
    issue(0, OP_LOAD,  4'd3, 16'h0,    16'h5555, 1'b1, 1'b0, "R4 foreign value kept");
    // R4 winning conditional store by other agent
    issue(0, OP_STORE, 4'd4, 16'h0400, 16'h0, 1'b0, 1'b0, "R4 init");
    issue(1, OP_LL,    4'd4, 16'h0,    16'h0400, 1'b1, 1'b0, "R4 a1 ll");
    issue(0, OP_LL,    4'd4, 16'h0,    16'h0400, 1'b1, 1'b0, "R4 a0 ll");
    issue(0, OP_SC,    4'd4, 16'h0401, 16'h0400, 1'b1, 1'b1, "R4 a0 sc wins");
    issue(1, OP_SC,    4'd4, 16'h0402, 16'h0401, 1'b1, 1'b0, "R4 a1 sc loses");
    issue(1, OP_LOAD,  4'd4, 16'h0,    16'h0401, 1'b1, 1'b0, "R4 loser wrote nothing");
    // R5
    issue(0, OP_STORE, 4'd5, 16'h0050, 16'h0, 1'b0, 1'b0, "R5 init");
    issue(0, OP_LL,    4'd3, 16'h0,    16'h5555, 1'b1, 1'b0, "R5 ll");
    issue(1, OP_STORE, 4'd5, 16'h0005, 16'h0050, 1'b1, 1'b0, "R5 store elsewhere");
    issue(0, OP_SC,    4'd3, 16'h6666, 16'h5555, 1'b1, 1'b1, "R5 sc still succeeds");
    // R6
    issue(0, OP_LL,    4'd3, 16'h0,    16'h6666, 1'b1, 1'b0, "R6 ll");
    issue(0, OP_STORE, 4'd3, 16'h1234, 16'h6666, 1'b1, 1'b0, "R6 own store");
    issue(0, OP_SC,    4'd3, 16'h4321, 16'h1234, 1'b1, 1'b1, "R6 sc succeeds");
    // R7
    issue(0, OP_LL,    4'd3, 16'h0,    16'h4321, 1'b1, 1'b0, "R7 ll old");
    issue(0, OP_LL,    4'd5, 16'h0,    16'h0005, 1'b1, 1'b0, "R7 ll new");
    issue(0, OP_SC,    4'd5, 16'hBBBB, 16'h0005, 1'b1, 1'b1, "R7 sc new addr");
    issue(0, OP_LL,    4'd5, 16'h0,    16'hBBBB, 1'b1, 1'b0, "R7 ll first");
    issue(0, OP_LL,    4'd3, 16'h0,    16'h4321, 1'b1, 1'b0, "R7 ll moved");
    issue(0, OP_SC,    4'd5, 16'hCCCC, 16'hBBBB, 1'b1, 1'b0, "R7 sc old addr fails");
    issue(0, OP_LOAD,  4'd5, 16'h0,    16'hBBBB, 1'b1, 1'b0, "R7 old addr unchanged");
    // R8 clear pulse
    issue(1, OP_LL,    4'd5, 16'h0,    16'hBBBB, 1'b1, 1'b0, "R8 ll");
    @(negedge clk); rsv_clr[1] = 1'b1;
    @(posedge clk); #1 rsv_clr[1] = 1'b0;
    issue(1, OP_SC,    4'd5, 16'hDDDD, 16'hBBBB, 1'b1, 1'b0, "R8 sc after clear");
    // R8 clear together with reserving load
    @(negedge clk);
    req_valid[1] = 1'b1; req_op[1] = OP_LL; req_addr[1] = 4'd5; req_wdata[1] = '0;
    rsv_clr[1] = 1'b1;
    #1;
    check(req_ready[1] == 1'b1, "R8 ll granted with clear", req_ready[1], 1);
    push(1, 16'hBBBB, 1'b1, 1'b0, "R8 ll with clear");
    @(posedge clk); #1 req_valid[1] = 1'b0; rsv_clr[1] = 1'b0;
    issue(1, OP_SC,    4'd5, 16'hEEEE, 16'hBBBB, 1'b1, 1'b0, "R8 clear beats ll");
    issue(1, OP_LOAD,  4'd5, 16'h0,    16'hBBBB, 1'b1, 1'b0, "R8 memory unchanged");
    // R9
    issue(0, OP_STORE, 4'd6, 16'h0060, 16'h0, 1'b0, 1'b0, "R9 init");
    issue(1, OP_LL,    4'd6, 16'h0,    16'h0060, 1'b1, 1'b0, "R9 a1 ll");
    pair(OP_STORE, 4'd6, 16'h0061, 16'h0060, 1'b1, 1'b0,
         OP_SC,    4'd6, 16'h0062, 16'h0061, 1'b0, "R9 store then sc");
    issue(0, OP_LOAD,  4'd6, 16'h0,    16'h0061, 1'b1, 1'b0, "R9 agent0 value kept");
    pair(OP_LOAD,  4'd6, 16'h0,    16'h0061, 1'b1, 1'b0,
         OP_STORE, 4'd6, 16'h0070, 16'h0061, 1'b0, "R9 load then store");
    issue(1, OP_LOAD,  4'd6, 16'h0,    16'h0070, 1'b1, 1'b0, "R9 agent1 store landed");

    repeat (4) @(negedge clk);
    check(q0.size() == 0 && q1.size() == 0, "R11 all responses seen",
          q0.size() + q1.size(), 0);
    finish_run();
  end
endmodule